// File: doc/BRIEF.md
# Partial-Width Register Write Merger

This block is a bank of sixteen 64-bit general-purpose registers with one write port and two read ports. Each access names a view of the register: the low byte, the second byte of the low word, the low 16 bits, the low 32 bits or the whole 64 bits. A write does not always replace the register. The block merges the new bits into the old contents under fixed aliasing rules. Narrow 8-bit and 16-bit writes keep every bit they do not cover. A 32-bit write clears the upper half.

The second-byte view is a legal write target only on the lowest four registers. A write to it on any other index is dropped, and so is a write that carries an undefined view code. In both cases an error strobe rises for one cycle. Reads are combinational. Each read port returns its chosen view shifted down to bit 0 and padded with zeros, so a consumer never has to mask or shift.

Top module: `gpr_merge_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all sixteen registers to zero and leaves `wr_err` low.
- R2: A write with view code 4 (full) stores all 64 bits of `wr_data` into the indexed register.
- R3: A write with view code 3 (32-bit) stores `wr_data[31:0]` into bits 31:0 and forces bits 63:32 to zero.
- R4: A write with view code 2 (16-bit) stores `wr_data[15:0]` into bits 15:0 and keeps bits 63:16.
- R5: A write with view code 0 (low byte) stores `wr_data[7:0]` into bits 7:0 and keeps bits 63:8.
- R6: A write with view code 1 (second byte) to index 0, 1, 2 or 3 stores `wr_data[7:0]` into bits 15:8 and keeps all other bits.
- R7: A write with view code 1 to index 4 or above changes no register, and `wr_err` is high for exactly the one cycle after that clock edge.
- R8: A write with an undefined view code (5, 6 or 7) changes no register and raises `wr_err` for the following cycle.
- R9: Each read port returns the selected view right-aligned and zero-extended: code 0 gives bits 7:0, code 1 gives bits 15:8 in output bits 7:0 (for any index), code 2 gives bits 15:0, code 3 gives bits 31:0, code 4 gives all 64 bits, and codes 5 to 7 give zero.
- R10: A read of the register being written in the same cycle returns the value from before the write. The new value is visible after the clock edge.
- R11: With `wr_en` low no register changes and `wr_err` stays low, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_view | input | 3 | View code of the write |
| wr_data | input | 64 | Write data, right-aligned for narrow views |
| rd0_idx | input | 4 | Register read on port 0 |
| rd0_view | input | 3 | View code of read port 0 |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd1_idx | input | 4 | Register read on port 1 |
| rd1_view | input | 3 | View code of read port 1 |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| wr_err | output | 1 | One-cycle strobe after a rejected write |

## Verification
The assertions assume that the write inputs are stable around each rising edge and free of X while `wr_en` is high. They also assume that reset is held for at least one edge before any write is checked. The bench therefore drives every input at the falling edge and holds it through the next rising edge. It asserts reset for two edges first, and it applies undefined view codes only on purpose, to exercise the rejection path.

// File: rtl/gprm_pkg.sv
package gprm_pkg;

    localparam int VIEW_W = 3;

    typedef enum logic [VIEW_W-1:0] {
        VW_LO8 = 3'd0,
        VW_HI8 = 3'd1,
        VW_W16 = 3'd2,
        VW_W32 = 3'd3,
        VW_W64 = 3'd4
    } view_e;

endpackage

// File: rtl/gprm_merge.sv
module gprm_merge
    import gprm_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int IDXW      = 4,
    parameter int HI8_LIMIT = 4
) (
    input  logic [XLEN-1:0]   old_val,
    input  logic [XLEN-1:0]   new_val,
    input  logic [VIEW_W-1:0] view,
    input  logic [IDXW-1:0]   idx,
    output logic [XLEN-1:0]   merged,
    output logic              legal
);

    localparam logic [IDXW:0] HI8_BOUND = (IDXW+1)'(HI8_LIMIT);

    logic hi8_ok;
    assign hi8_ok = ({1'b0, idx} < HI8_BOUND);

    always_comb begin
        merged = old_val;
        legal  = 1'b1;
        case (view)
            VW_LO8: merged[7:0]  = new_val[7:0];
            VW_HI8: begin
                if (hi8_ok) merged[15:8] = new_val[7:0];
                else        legal        = 1'b0;
            end
            VW_W16: merged[15:0] = new_val[15:0];
            VW_W32: merged       = XLEN'(new_val[31:0]);
            VW_W64: merged       = new_val;
            default: legal       = 1'b0;
        endcase
    end

endmodule

// File: rtl/gprm_view_rd.sv
module gprm_view_rd
    import gprm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   reg_val,
    input  logic [VIEW_W-1:0] view,
    output logic [XLEN-1:0]   data
);

    always_comb begin
        case (view)
            VW_LO8:  data = XLEN'(reg_val[7:0]);
            VW_HI8:  data = XLEN'(reg_val[15:8]);
            VW_W16:  data = XLEN'(reg_val[15:0]);
            VW_W32:  data = XLEN'(reg_val[31:0]);
            VW_W64:  data = reg_val;
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/gpr_merge_file.sv
module gpr_merge_file
    import gprm_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int XLEN      = 64,
    parameter int HI8_LIMIT = 4,
    parameter int NRD       = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [VIEW_W-1:0]        wr_view,
    input  logic [XLEN-1:0]          wr_data,
    input  logic [$clog2(NREG)-1:0]  rd0_idx,
    input  logic [VIEW_W-1:0]        rd0_view,
    output logic [XLEN-1:0]          rd0_data,
    input  logic [$clog2(NREG)-1:0]  rd1_idx,
    input  logic [VIEW_W-1:0]        rd1_view,
    output logic [XLEN-1:0]          rd1_data,
    output logic                     wr_err
);

    localparam int IDXW = $clog2(NREG);
    localparam logic [IDXW:0] HI8_BOUND = (IDXW+1)'(HI8_LIMIT);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        logic                      err;
    } state_t;

    state_t s_d, s_q;

    logic [XLEN-1:0] merged_d;
    logic            legal_d;

    gprm_merge #(
        .XLEN      (XLEN),
        .IDXW      (IDXW),
        .HI8_LIMIT (HI8_LIMIT)
    ) u_merge (
        .old_val (s_q.regs[wr_idx]),
        .new_val (wr_data),
        .view    (wr_view),
        .idx     (wr_idx),
        .merged  (merged_d),
        .legal   (legal_d)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (wr_en) begin
            if (legal_d) s_d.regs[wr_idx] = merged_d;
            else         s_d.err          = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign wr_err = s_q.err;

    // Read ports
    logic [NRD-1:0][IDXW-1:0]   rd_idx_a;
    logic [NRD-1:0][VIEW_W-1:0] rd_view_a;
    logic [NRD-1:0][XLEN-1:0]   rd_data_a;

    assign rd_idx_a  = {rd1_idx, rd0_idx};
    assign rd_view_a = {rd1_view, rd0_view};
    assign rd0_data  = rd_data_a[0];
    assign rd1_data  = rd_data_a[1];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gprm_view_rd #(.XLEN(XLEN)) u_rd (
            .reg_val (s_q.regs[rd_idx_a[p]]),
            .view    (rd_view_a[p]),
            .data    (rd_data_a[p])
        );
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (s_q.regs == '0 && !wr_err));

    // R3
    w32_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == VW_W32) |=> (s_q.regs[$past(wr_idx)][XLEN-1:32] == '0));

    // R4
    w16_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == VW_W16)
        |=> (s_q.regs[$past(wr_idx)][XLEN-1:16] == $past(s_q.regs[wr_idx][XLEN-1:16])));

    // R5
    lo8_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == VW_LO8)
        |=> (s_q.regs[$past(wr_idx)][XLEN-1:8] == $past(s_q.regs[wr_idx][XLEN-1:8])));

    // R7
    hi8_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == VW_HI8 && {1'b0, wr_idx} >= HI8_BOUND)
        |=> (wr_err && $stable(s_q.regs)));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(s_q.regs) && !wr_err));

endmodule

// File: tb/gpr_merge_file_test.sv
`timescale 1ns/1ps
module gpr_merge_file_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [2:0]  wr_view;
    logic [63:0] wr_data;
    logic [3:0]  rd0_idx, rd1_idx;
    logic [2:0]  rd0_view, rd1_view;
    logic [63:0] rd0_data, rd1_data;
    logic        wr_err;

    always #2.5 clk = ~clk;

    gpr_merge_file uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data),
        .wr_err(wr_err)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  widx;
        logic [2:0]  wview;
        logic [63:0] wdata;
        logic [3:0]  ridx;
        logic [2:0]  rview;
        logic [63:0] exp;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    // view codes: 0 low byte, 1 second byte, 2 16-bit, 3 32-bit, 4 full
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd2,  3'd4, 64'h1122334455667788, 4'd2,  3'd4, 64'h1122334455667788, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd2,  3'd0, 64'hFFFFFFFFFFFFFFAA, 4'd2,  3'd4, 64'h11223344556677AA, 1'b0, 4'd5},  // R5
        '{1'b1, 4'd2,  3'd1, 64'h00000000000000BB, 4'd2,  3'd4, 64'h112233445566BBAA, 1'b0, 4'd6},  // R6
        '{1'b1, 4'd2,  3'd2, 64'hFFFFFFFFFFFFCCDD, 4'd2,  3'd4, 64'h112233445566CCDD, 1'b0, 4'd4},  // R4
        '{1'b1, 4'd2,  3'd3, 64'hFFFFFFFF87654321, 4'd2,  3'd4, 64'h0000000087654321, 1'b0, 4'd3},  // R3
        '{1'b1, 4'd5,  3'd4, 64'hDEADBEEFCAFEF00D, 4'd5,  3'd4, 64'hDEADBEEFCAFEF00D, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd5,  3'd1, 64'h0000000000000077, 4'd5,  3'd4, 64'hDEADBEEFCAFEF00D, 1'b1, 4'd7},  // R7
        '{1'b0, 4'd2,  3'd4, 64'hFFFFFFFFFFFFFFFF, 4'd2,  3'd4, 64'h0000000087654321, 1'b0, 4'd11}, // R11, R7 pulse ends
        '{1'b0, 4'd0,  3'd0, 64'h0,                4'd5,  3'd1, 64'h00000000000000F0, 1'b0, 4'd9},  // R9
        '{1'b0, 4'd0,  3'd0, 64'h0,                4'd5,  3'd2, 64'h000000000000F00D, 1'b0, 4'd9},  // R9
        '{1'b0, 4'd0,  3'd0, 64'h0,                4'd5,  3'd0, 64'h000000000000000D, 1'b0, 4'd9},  // R9
        '{1'b0, 4'd0,  3'd0, 64'h0,                4'd5,  3'd3, 64'h00000000CAFEF00D, 1'b0, 4'd9},  // R9
        '{1'b1, 4'd2,  3'd6, 64'hFFFFFFFFFFFFFFFF, 4'd2,  3'd4, 64'h0000000087654321, 1'b1, 4'd8},  // R8
        '{1'b1, 4'd15, 3'd4, 64'hFFFFFFFFFFFFFFFF, 4'd15, 3'd4, 64'hFFFFFFFFFFFFFFFF, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd15, 3'd0, 64'h0000000000000000, 4'd15, 3'd4, 64'hFFFFFFFFFFFFFF00, 1'b0, 4'd5},  // R5
        '{1'b1, 4'd3,  3'd1, 64'h000000000000005A, 4'd3,  3'd4, 64'h0000000000005A00, 1'b0, 4'd6},  // R6
        '{1'b0, 4'd0,  3'd0, 64'h0,                4'd5,  3'd7, 64'h0000000000000000, 1'b0, 4'd9},  // R9
        '{1'b1, 4'd0,  3'd1, 64'hFFFFFFFFFFFFFFA5, 4'd0,  3'd1, 64'h00000000000000A5, 1'b0, 4'd6},  // R6
        '{1'b1, 4'd4,  3'd1, 64'h0000000000000011, 4'd4,  3'd4, 64'h0000000000000000, 1'b1, 4'd7}   // R7
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
        rd0_idx = '0; rd0_view = 3'd4; rd1_idx = 4'd15; rd1_view = 3'd4;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 r0", rd0_data, 64'h0);
        check("R1 r15", rd1_data, 64'h0);
        check("R1 err", {63'h0, wr_err}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            wr_en   = VECS[i].we;
            wr_idx  = VECS[i].widx;
            wr_view = VECS[i].wview;
            wr_data = VECS[i].wdata;
            rd0_idx = VECS[i].ridx;
            rd0_view = VECS[i].rview;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d data", VECS[i].req, i), rd0_data, VECS[i].exp);
            check($sformatf("R%0d vec%0d err", VECS[i].req, i), {63'h0, wr_err}, {63'h0, VECS[i].eerr});
        end

        // R10: same-cycle read sees the old value on port 1
        wr_en = 1'b1; wr_idx = 4'd2; wr_view = 3'd4; wr_data = 64'hAAAA5555AAAA5555;
        rd1_idx = 4'd2; rd1_view = 3'd4;
        #1;
        check("R10 pre-edge", rd1_data, 64'h0000000087654321);
        @(posedge clk);
        @(negedge clk);
        check("R10 post-edge", rd1_data, 64'hAAAA5555AAAA5555);
        wr_en = 1'b0;

        // R1: reset in mid-run clears contents
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd0_idx = 4'd5; rd0_view = 3'd4;
        #1;
        check("R1 mid r2", rd1_data, 64'h0);
        check("R1 mid r5", rd0_data, 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule